// File: doc/BRIEF.md
# Serial Receive Back End with Multiprocessor Wakeup

This block sits behind the bit-sampling front end of an asynchronous serial receiver. The front end delivers one deserialized frame per handshake, along with the error indications it gathered for that frame: noise, a framing fault and a parity fault. It also sends a single-cycle pulse when it sees an idle line. The back end keeps the last received byte in a data register. It maintains a receive-ready flag and four sticky error flags, and it drives a single interrupt request.

The block supports a multiprocessor mute state. While muted, incoming frames still overwrite the data register, but no flag moves. The receiver leaves the mute state by itself when it sees the wakeup pattern selected by `wake_sel`. With `wake_sel` at 0 the pattern is an idle-line pulse. With `wake_sel` at 1 it is an address mark, meaning a frame whose data MSB is 1. Software uses a single-cycle write strobe to clear flags and to put the receiver back into the mute state.

The frame input is a valid/ready stream. `frm_ready` is held high, so the block never applies back-pressure. A frame is taken on every clock edge where `frm_valid` is high. If software has not consumed the previous frame, the loss is reported as an overrun rather than by stalling the front end.

Top module: `rxb_rx_backend`

## Requirements
- R1: `frm_ready` is 1 in every cycle after reset, and every cycle with `frm_valid` high completes exactly one frame.
- R2: An accepted frame that is not muted, arriving while ready (`rx_flags[0]`) is 0, loads `rx_data` and sets `rx_flags[0]`. Both are visible on the clock edge that accepts the frame.
- R3: An accepted frame that is not muted, arriving while `rx_flags[0]` is 1, sets the overrun flag `rx_flags[1]`. `rx_data` keeps the older byte. The noise, framing and parity flags do not change for that frame.
- R4: Without overrun, an accepted frame ORs `frm_noise` into `rx_flags[2]`, `frm_ferr` into `rx_flags[3]` and `frm_perr` into `rx_flags[4]`. Any combination may be set together.
- R5: While `mute` is 1, a frame that is not a wakeup frame loads `rx_data` and changes no bit of `rx_flags`. This includes no overrun.
- R6: With `wake_sel`=0, an `idle_seen` pulse while muted clears `mute` at the next edge. The next frame is then handled as a normal frame. With `wake_sel`=0, a frame's MSB has no effect on `mute`.
- R7: With `wake_sel`=1, a muted frame whose `frm_data` MSB is 1 clears `mute` and is itself handled as a normal frame (R2/R3/R4). With `wake_sel`=1, `idle_seen` has no effect.
- R8: `sw_wr` with `sw_mute`=1 sets `mute` at the next edge. This wins over a hardware wakeup in the same cycle.
- R9: `sw_wr` clears each `rx_flags` bit whose `sw_clr` bit is 1. A flag being set by a frame in the same cycle stays set.
- R10: `irq` is 1 exactly when `rx_flags[0]` is 1, or when some error flag `rx_flags[k]` (k=1..4) is 1 with `err_irq_en[k-1]` set.
- R11: After reset, `rx_data`, `rx_flags`, `mute` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame from the front end is complete |
| frm_ready | output | 1 | Always 1: no back-pressure |
| frm_data | input | DW | Frame data bits |
| frm_noise | input | 1 | Noise seen while sampling this frame |
| frm_ferr | input | 1 | Stop bit of this frame sampled low |
| frm_perr | input | 1 | Parity mismatch in this frame |
| idle_seen | input | 1 | Single-cycle idle-line detection pulse |
| wake_sel | input | 1 | 0: idle-line wakeup, 1: address-mark wakeup |
| sw_wr | input | 1 | Software write strobe |
| sw_clr | input | 5 | Write-one-to-clear mask over `rx_flags` |
| sw_mute | input | 1 | With `sw_wr`, enter the mute state |
| err_irq_en | input | 4 | Interrupt enables for overrun, noise, framing, parity |
| rx_data | output | DW | Received data register |
| rx_flags | output | 5 | {parity, framing, noise, overrun, ready} |
| mute | output | 1 | Receiver is in the wakeup (mute) state |
| irq | output | 1 | Interrupt request |

## Verification
Three pairs of functions can fall in the same cycle. A frame can arrive while a software clear of the ready flag is being applied. A software mute request can coincide with an idle pulse or an address-mark frame. A frame can also complete in the very cycle the idle pulse releases the mute state. Directed steps force each pair into one cycle, and a long random run with dense events hits them again. A behavioural model in the bench judges every cycle. In that model, a set wins over a clear, software mute wins over hardware wakeup, and the mute value before the edge decides how a frame is handled.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int NFLAG = 5;
  localparam int F_RDY = 0;
  localparam int F_OVR = 1;
  localparam int F_NSE = 2;
  localparam int F_FRM = 3;
  localparam int F_PAR = 4;
  localparam int NERR  = NFLAG - 1;
endpackage

// File: rtl/rxb_wake_ctl.sv
module rxb_wake_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_evt,
  input  logic frame_msb,
  input  logic idle_evt,
  input  logic wake_sel,
  input  logic mute_req,
  output logic mute,
  output logic addr_wake
);
  logic mute_q, hw_wake;

  assign addr_wake = frame_evt & mute_q & wake_sel & frame_msb;
  assign hw_wake   = mute_q & ((idle_evt & ~wake_sel) | addr_wake);
  assign mute      = mute_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mute_q <= 1'b0;
    else if (mute_req) mute_q <= 1'b1;
    else if (hw_wake)  mute_q <= 1'b0;
  end

  assert_idle_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && idle_evt && !wake_sel && !mute_req) |=> !mute_q);
  assert_addr_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_evt && mute_q && wake_sel && frame_msb && !mute_req) |=> !mute_q);
  assert_sw_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |=> mute_q);
endmodule

// File: rtl/rxb_flag_bank.sv
module rxb_flag_bank
  import rxb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             noise,
  input  logic             ferr,
  input  logic             perr,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flags,
  output logic             overrun
);
  logic [NFLAG-1:0] q, set_v;

  assign overrun = accept & q[F_RDY];
  assign flags   = q;

  always_comb begin
    set_v = '0;
    if (accept) begin
      if (q[F_RDY]) begin
        set_v[F_OVR] = 1'b1;
      end else begin
        set_v[F_RDY] = 1'b1;
        set_v[F_NSE] = noise;
        set_v[F_FRM] = ferr;
        set_v[F_PAR] = perr;
      end
    end
  end

  for (genvar k = 0; k < NFLAG; k++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[k] <= 1'b0;
      else if (set_v[k]) q[k] <= 1'b1;
      else if (clr[k])   q[k] <= 1'b0;
    end
  end

  assert_ready_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !q[F_RDY]) |=> q[F_RDY]);
  assert_err_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && q[F_RDY] && clr[F_PAR:F_NSE] == 3'b000) |=> $stable(q[F_PAR:F_NSE]));
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[F_NSE] && !accept) |=> !q[F_NSE]);
endmodule

// File: rtl/rxb_rx_backend.sv
module rxb_rx_backend
  import rxb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [DW-1:0]    frm_data,
  input  logic             frm_noise,
  input  logic             frm_ferr,
  input  logic             frm_perr,
  input  logic             idle_seen,
  input  logic             wake_sel,
  input  logic             sw_wr,
  input  logic [NFLAG-1:0] sw_clr,
  input  logic             sw_mute,
  input  logic [NERR-1:0]  err_irq_en,
  output logic [DW-1:0]    rx_data,
  output logic [NFLAG-1:0] rx_flags,
  output logic             mute,
  output logic             irq
);
  localparam int MSB = DW - 1;

  logic             addr_wake, accept, overrun, load;
  logic [NFLAG-1:0] clr_v;
  logic [DW-1:0]    data_q;

  assign frm_ready = 1'b1;
  assign clr_v     = sw_wr ? sw_clr : '0;

  rxb_wake_ctl u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_evt (frm_valid),
    .frame_msb (frm_data[MSB]),
    .idle_evt  (idle_seen),
    .wake_sel  (wake_sel),
    .mute_req  (sw_wr & sw_mute),
    .mute      (mute),
    .addr_wake (addr_wake)
  );

  assign accept = frm_valid & (~mute | addr_wake);

  rxb_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .noise   (frm_noise),
    .ferr    (frm_ferr),
    .perr    (frm_perr),
    .clr     (clr_v),
    .flags   (rx_flags),
    .overrun (overrun)
  );

  assign load = frm_valid & ~overrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= frm_data;
  end
  assign rx_data = data_q;

  assign irq = rx_flags[F_RDY] | (|(rx_flags[NFLAG-1:1] & err_irq_en));

  assert_muted_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && mute && !addr_wake && clr_v == '0) |=> $stable(rx_flags));
  assert_muted_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && mute && !addr_wake) |=> rx_data == $past(frm_data));
  assert_data_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_flags[F_RDY]) |=> $stable(rx_data));
  assert_ready_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> frm_ready);
endmodule

// File: tb/test_rxb_rx_backend.sv
module test_rxb_rx_backend;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_valid = 0, frm_noise = 0, frm_ferr = 0, frm_perr = 0;
  logic [7:0] frm_data = '0;
  logic       idle_seen = 0, wake_sel = 0, sw_wr = 0, sw_mute = 0;
  logic [4:0] sw_clr = '0;
  logic [3:0] err_irq_en = '0;
  logic       frm_ready, mute, irq;
  logic [7:0] rx_data;
  logic [4:0] rx_flags;

  logic [7:0] m_data;
  logic [4:0] m_flags;
  logic       m_mute;
  int vectors = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  rxb_rx_backend i_rxb_rx_backend (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_data(frm_data), .frm_noise(frm_noise), .frm_ferr(frm_ferr),
    .frm_perr(frm_perr), .idle_seen(idle_seen), .wake_sel(wake_sel),
    .sw_wr(sw_wr), .sw_clr(sw_clr), .sw_mute(sw_mute), .err_irq_en(err_irq_en),
    .rx_data(rx_data), .rx_flags(rx_flags), .mute(mute), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic compare(string tag);
    logic exp_irq;
    exp_irq = m_flags[0] | (|(m_flags[4:1] & err_irq_en));
    vectors++;
    if (frm_ready !== 1'b1) begin fails++;
      $display("FAIL R1 %s frm_ready act %b exp 1", tag, frm_ready); end
    if (rx_data !== m_data) begin fails++;
      $display("FAIL R2/R3/R5 %s rx_data act %h exp %h", tag, rx_data, m_data); end
    if (rx_flags[1:0] !== m_flags[1:0]) begin fails++;
      $display("FAIL R2/R3/R9 %s ready/ovr act %b exp %b", tag, rx_flags[1:0], m_flags[1:0]); end
    if (rx_flags[4:2] !== m_flags[4:2]) begin fails++;
      $display("FAIL R4/R9 %s err flags act %b exp %b", tag, rx_flags[4:2], m_flags[4:2]); end
    if (mute !== m_mute) begin fails++;
      $display("FAIL R6/R7/R8 %s mute act %b exp %b", tag, mute, m_mute); end
    if (irq !== exp_irq) begin fails++;
      $display("FAIL R10 %s irq act %b exp %b", tag, irq, exp_irq); end
  endtask

  // Drive one cycle of stimulus, advance the reference model, compare after the edge.
  task automatic tick(string tag, bit v = 0, logic [7:0] d = 0, bit n = 0, bit fe = 0,
                      bit pe = 0, bit idl = 0, bit ws = 0, bit wr = 0,
                      logic [4:0] clr = 0, bit sm = 0);
    bit addr, acc, ovr;
    frm_valid = v; frm_data = d; frm_noise = n; frm_ferr = fe; frm_perr = pe;
    idle_seen = idl; wake_sel = ws; sw_wr = wr; sw_clr = clr; sw_mute = sm;
    addr = v && m_mute && ws && d[7];
    acc  = v && (!m_mute || addr);
    ovr  = acc && m_flags[0];
    if (wr) m_flags = m_flags & ~clr;
    if (acc && ovr) m_flags[1] = 1'b1;
    if (acc && !ovr) begin
      m_flags[0] = 1'b1;
      m_flags[2] = m_flags[2] | n;
      m_flags[3] = m_flags[3] | fe;
      m_flags[4] = m_flags[4] | pe;
    end
    if (v && !ovr) m_data = d;
    if (wr && sm) m_mute = 1'b1;
    else if (m_mute && ((idl && !ws) || addr)) m_mute = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    m_data = '0; m_flags = '0; m_mute = 1'b0;
    repeat (3) @(negedge clk);
    compare("R11 reset");
    rst_n = 1'b1;
    err_irq_en = 4'b1111;
    tick("idle");
    // R2 normal frame
    tick("R2 load", 1, 8'h35);
    tick("R2 hold");
    // R3 overrun: data kept, noise masked
    tick("R3 overrun", 1, 8'h77, 1, 1, 1);
    tick("R9 clear all", 0, 0, 0, 0, 0, 0, 0, 1, 5'h1f);
    // R4 all errors together
    tick("R4 errors", 1, 8'h12, 1, 1, 1);
    tick("R9 clear errs only", 0, 0, 0, 0, 0, 0, 0, 1, 5'h1c);
    tick("R9 clear ready", 0, 0, 0, 0, 0, 0, 0, 1, 5'h01);
    // R8 software mute, idle-line mode
    tick("R8 mute", 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    tick("R5 muted frame", 1, 8'h44, 1, 1, 0);
    tick("R5 muted frame2", 1, 8'h45);
    tick("R6 msb ignored", 1, 8'hC1, 0, 0, 0, 0, 0);
    tick("R7 idle ignored sel1", 0, 0, 0, 0, 0, 1, 1);
    tick("R6 idle wake", 0, 0, 0, 0, 0, 1, 0);
    tick("R6 address frame", 1, 8'h0A);
    tick("R9 clr", 0, 0, 0, 0, 0, 0, 0, 1, 5'h1f);
    // R7 address-mark mode
    tick("R8 mute again", 0, 0, 0, 0, 0, 0, 1, 1, 0, 1);
    tick("R7 msb0 muted", 1, 8'h7F, 0, 0, 1, 0, 1);
    tick("R7 msb1 wakes", 1, 8'h93, 0, 1, 0, 0, 1);
    tick("R7 overrun after wake", 1, 8'h11, 0, 0, 0, 0, 1);
    // R9 set wins over clear in same cycle
    tick("R9 clr all", 0, 0, 0, 0, 0, 0, 0, 1, 5'h1f);
    tick("R9 frame", 1, 8'h21);
    tick("R9 frame+clear ready", 1, 8'h22, 0, 0, 0, 0, 0, 1, 5'h01);
    tick("R9 frame+clear ready2", 1, 8'h23, 0, 0, 0, 0, 0, 1, 5'h01);
    // R8 software mute beats idle wake
    tick("R8 mute", 0, 0, 0, 0, 0, 0, 0, 1, 5'h1f, 1);
    tick("R8 mute beats idle", 0, 0, 0, 0, 0, 1, 0, 1, 0, 1);
    tick("R6 frame in wake cycle", 1, 8'h5A, 0, 0, 0, 1, 0);
    tick("R6 next frame normal", 1, 8'h5B);
    // R10 irq enables
    err_irq_en = 4'b0010;
    tick("R10 clr", 0, 0, 0, 0, 0, 0, 0, 1, 5'h1f);
    tick("R10 parity only", 1, 8'h01, 0, 0, 1);
    tick("R10 clr ready", 0, 0, 0, 0, 0, 0, 0, 1, 5'h01);
    tick("R10 noise", 1, 8'h02, 1);
    tick("R10 clr ready2", 0, 0, 0, 0, 0, 0, 0, 1, 5'h01);
    // Dense random run
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      err_irq_en = r[27:24];
      tick("rand", r[0] & r[1], r[15:8], r[2], r[3], r[4], r[5] & r[6], r[7],
           r[16] & r[17], r[22:18], r[23] & r[28] & r[29]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule